// File: doc/BRIEF.md
# Channel Sequencer and Power-Mode Controller

This block sits beside the conversion engine of a two-input successive-approximation converter. For every frame it decides which input channel is converted next, which output coding and reference choice apply, and whether the converter core and the internal reference are powered. Its inputs are a one-cycle configuration update strobe with the decoded control fields, an end-of-conversion pulse, and single-cycle pulses marking the falling and rising edges of the frame select.

There are four power modes. In the two automatic modes the core drops out at the end of a valid conversion and wakes on the next frame-select falling edge. The frame that runs during the wake-up is a dummy, so the block holds `result_valid` low until that frame ends. Full shutdown is left only by rewriting the mode field and then seeing a frame-select rising edge. One combination of the sequence field and a non-zero address makes the channel pointer step from channel 0 up to the address and wrap. Every other combination converts the addressed channel.

Top module: `seqpm_ctrl`

## Requirements
- R1: After reset: core_pwr_en=1, ref_pwr_en=0, coding_sel=0, int_ref_sel=0, next_ch=0 and result_valid=1. The mode and sequence fields reset to 00 and the address resets to 0.
- R2: A cfg_wr pulse loads pm_in, seq_in, addr_in, coding_in and int_ref_in, and they take effect in the cycle after it. Without cfg_wr the stored fields never change, in every power state.
- R3: While pm is 00 (normal), conversions never remove core power.
- R4: With pm 01 (auto standby) or 10 (auto shutdown), a conv_done while core_pwr_en=1 and result_valid=1 clears core_pwr_en in the next cycle. A conv_done while asleep has no effect.
- R5: While asleep in an automatic mode, cs_fall sets core_pwr_en=1 and result_valid=0 in the next cycle. The conv_done that ends this dummy frame keeps the core powered and sets result_valid=1.
- R6: A cfg_wr with pm_in=11 clears core_pwr_en and ref_pwr_en in the next cycle, from any state. While fully shut down, cs_fall and cs_rise have no effect.
- R7: From full shutdown, a cfg_wr with pm_in other than 11 keeps the core off. The next cs_rise then powers the core, with result_valid=0 until the following conv_done.
- R8: Unless sequence mode is active, next_ch equals the stored address.
- R9: Sequence mode is active when the stored seq field is 2'b10 and the stored address is non-zero. The pointer is 0 on entry, advances by one on each conv_done, and wraps to 0 after the address. A rewrite that keeps sequence mode active keeps the pointer.
- R10: A cfg_wr that changes int_ref_in from the stored value drives result_valid to 0 in the next cycle. It stays 0 until a conv_done while the core is powered.
- R11: ref_pwr_en is 1 only when int_ref_sel=1 and the core is either powered or asleep with pm 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration update strobe |
| pm_in | input | 2 | Power mode field: 00 normal, 01 auto standby, 10 auto shutdown, 11 full shutdown |
| seq_in | input | 2 | Sequence field; 2'b10 requests sequencing |
| addr_in | input | CH_W | Channel address |
| coding_in | input | 1 | Output coding select (0 two's complement, 1 straight binary) |
| int_ref_in | input | 1 | 1 selects the internal reference |
| conv_done | input | 1 | End-of-conversion pulse |
| cs_fall | input | 1 | Frame-select falling-edge pulse |
| cs_rise | input | 1 | Frame-select rising-edge pulse |
| next_ch | output | CH_W | Channel for the next conversion |
| coding_sel | output | 1 | Active output coding |
| int_ref_sel | output | 1 | Active reference choice |
| core_pwr_en | output | 1 | Converter core power enable |
| ref_pwr_en | output | 1 | Internal reference power enable |
| result_valid | output | 1 | Low while the current frame's result is unreliable |

## Verification
The bench walks a single core through a wake-up and checks that it stays awake across the dummy frame. A design that slept again at once would never raise result_valid in the automatic modes. It fires frame-select edges during full shutdown, both before and after the mode field is rewritten. An early exit would show up as core power returning on a falling edge or without any rewrite. For the sequencer, it checks that a repeated write keeps the pointer and that re-entry clears it. A pointer reset on every write would stall the rotation on channel 0, and a missing reset would resume mid-rotation. It also checks that an address of 0 with the sequence pattern still selects channel 0 directly.

// File: rtl/seqpm_pkg.sv
package seqpm_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL    = 2'b00,
    PM_AUTO_STBY = 2'b01,
    PM_AUTO_SHDN = 2'b10,
    PM_FULL_OFF  = 2'b11
  } pm_e;

  typedef enum logic [1:0] {
    PS_ON      = 2'b00,
    PS_SLEEP   = 2'b01,
    PS_FULL    = 2'b10,
    PS_RELEASE = 2'b11
  } pstate_e;

  localparam logic [1:0] SEQ_ROTATE = 2'b10;

  // automatic modes drop power at the end of a valid conversion
  function automatic logic pm_is_auto(input logic [1:0] pm);
    return (pm == PM_AUTO_STBY) || (pm == PM_AUTO_SHDN);
  endfunction

  // sequencing needs the rotate pattern and a non-zero last channel
  function automatic logic seq_engaged(input logic [1:0] seq, input logic addr_nz);
    return (seq == SEQ_ROTATE) && addr_nz;
  endfunction

endpackage

// File: rtl/seqpm_cfg_regs.sv
module seqpm_cfg_regs
  import seqpm_pkg::*;
#(
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [1:0]      pm_in,
  input  logic [1:0]      seq_in,
  input  logic [CH_W-1:0] addr_in,
  input  logic            coding_in,
  input  logic            int_ref_in,
  output logic [1:0]      pm_q,
  output logic [CH_W-1:0] addr_q,
  output logic            coding_q,
  output logic            ref_q,
  output logic            ref_change,
  output logic            seq_enter,
  output logic            seq_on
);

  logic [1:0] seq_q;
  logic       seq_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q     <= PM_NORMAL;
      seq_q    <= 2'b00;
      addr_q   <= '0;
      coding_q <= 1'b0;
      ref_q    <= 1'b0;
    end else if (cfg_wr) begin
      pm_q     <= pm_in;
      seq_q    <= seq_in;
      addr_q   <= addr_in;
      coding_q <= coding_in;
      ref_q    <= int_ref_in;
    end
  end

  assign seq_on     = seq_engaged(seq_q, addr_q != '0);
  assign seq_next   = seq_engaged(seq_in, addr_in != '0);
  assign seq_enter  = cfg_wr && seq_next && !seq_on;
  assign ref_change = cfg_wr && (int_ref_in != ref_q);

endmodule

// File: rtl/seqpm_pwr_fsm.sv
module seqpm_pwr_fsm
  import seqpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] pm_in,
  input  logic [1:0] pm_q,
  input  logic       ref_q,
  input  logic       ref_change,
  input  logic       conv_done,
  input  logic       cs_fall,
  input  logic       cs_rise,
  output pstate_e    state,
  output logic       wake_evt,
  output logic       stale,
  output logic       core_pwr_en,
  output logic       ref_pwr_en
);

  pstate_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_ON:      if (conv_done && !stale && pm_is_auto(pm_q)) nxt = PS_SLEEP;
      PS_SLEEP:   if (cs_fall) nxt = PS_ON;
      PS_FULL:    if (cfg_wr && (pm_in != PM_FULL_OFF)) nxt = PS_RELEASE;
      PS_RELEASE: if (cs_rise) nxt = PS_ON;
    endcase
    if (cfg_wr && (pm_in == PM_FULL_OFF)) nxt = PS_FULL;
  end

  assign wake_evt = ((state == PS_SLEEP) || (state == PS_RELEASE)) && (nxt == PS_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_ON;
      stale <= 1'b0;
    end else begin
      state <= nxt;
      if (wake_evt || ref_change)
        stale <= 1'b1;
      else if (conv_done && (state == PS_ON))
        stale <= 1'b0;
    end
  end

  assign core_pwr_en = (state == PS_ON);
  assign ref_pwr_en  = ref_q &&
                       ((state == PS_ON) || ((state == PS_SLEEP) && (pm_q == PM_AUTO_STBY)));

endmodule

// File: rtl/seqpm_ch_seq.sv
module seqpm_ch_seq #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seq_on,
  input  logic            seq_enter,
  input  logic [CH_W-1:0] addr_q,
  input  logic            conv_done,
  output logic [CH_W-1:0] next_ch,
  output logic            ptr_wrap
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] ptr;

  // pointer rolls back to 0 past the address (and past the channel count)
  function automatic logic [CH_W-1:0] step_ptr(input logic [CH_W-1:0] p,
                                               input logic [CH_W-1:0] last);
    if ((p >= last) || (p >= LAST_CH)) return '0;
    return p + 1'b1;
  endfunction

  assign ptr_wrap = seq_on && conv_done && (step_ptr(ptr, addr_q) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (seq_enter)
      ptr <= '0;
    else if (seq_on && conv_done)
      ptr <= step_ptr(ptr, addr_q);
  end

  assign next_ch = seq_on ? ptr : addr_q;

endmodule

// File: rtl/seqpm_ctrl.sv
module seqpm_ctrl
  import seqpm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [1:0]      pm_in,
  input  logic [1:0]      seq_in,
  input  logic [CH_W-1:0] addr_in,
  input  logic            coding_in,
  input  logic            int_ref_in,
  input  logic            conv_done,
  input  logic            cs_fall,
  input  logic            cs_rise,
  output logic [CH_W-1:0] next_ch,
  output logic            coding_sel,
  output logic            int_ref_sel,
  output logic            core_pwr_en,
  output logic            ref_pwr_en,
  output logic            result_valid
);

  logic [1:0]      pm_q;
  logic [CH_W-1:0] addr_q;
  logic            ref_change;
  logic            seq_enter;
  logic            seq_on;
  logic            wake_evt;
  logic            stale;
  logic            ptr_wrap;
  pstate_e         pstate;

  seqpm_cfg_regs #(.CH_W(CH_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .pm_in      (pm_in),
    .seq_in     (seq_in),
    .addr_in    (addr_in),
    .coding_in  (coding_in),
    .int_ref_in (int_ref_in),
    .pm_q       (pm_q),
    .addr_q     (addr_q),
    .coding_q   (coding_sel),
    .ref_q      (int_ref_sel),
    .ref_change (ref_change),
    .seq_enter  (seq_enter),
    .seq_on     (seq_on)
  );

  seqpm_pwr_fsm u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .pm_in       (pm_in),
    .pm_q        (pm_q),
    .ref_q       (int_ref_sel),
    .ref_change  (ref_change),
    .conv_done   (conv_done),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .state       (pstate),
    .wake_evt    (wake_evt),
    .stale       (stale),
    .core_pwr_en (core_pwr_en),
    .ref_pwr_en  (ref_pwr_en)
  );

  seqpm_ch_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_on    (seq_on),
    .seq_enter (seq_enter),
    .addr_q    (addr_q),
    .conv_done (conv_done),
    .next_ch   (next_ch),
    .ptr_wrap  (ptr_wrap)
  );

  assign result_valid = !stale;

endmodule

// File: rtl/seqpm_ctrl_chk.sv
module seqpm_ctrl_chk
  import seqpm_pkg::*;
#(
  parameter int CH_W = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [1:0]      pm_in,
  input logic            coding_in,
  input logic            int_ref_in,
  input logic            conv_done,
  input logic            cs_fall,
  input logic            cs_rise,
  input logic [CH_W-1:0] next_ch,
  input logic            coding_sel,
  input logic            int_ref_sel,
  input logic            core_pwr_en,
  input logic            ref_pwr_en,
  input logic            result_valid,
  input logic [1:0]      st,
  input logic [1:0]      pm_q,
  input logic            seq_on
);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (coding_sel == $past(coding_in)) && (int_ref_sel == $past(int_ref_in)));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(coding_sel) && $stable(int_ref_sel));

  // R3
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_en && (pm_q == PM_NORMAL) && !cfg_wr) |=> core_pwr_en);

  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_en && conv_done && result_valid && pm_is_auto(pm_q) && !cfg_wr) |=> !core_pwr_en);

  // R5
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PS_SLEEP) && cs_fall && !cfg_wr) |=> (core_pwr_en && !result_valid));

  // R5
  dummy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!result_valid && conv_done && core_pwr_en && !cfg_wr) |=> (result_valid && core_pwr_en));

  // R6
  full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (pm_in == PM_FULL_OFF)) |=> (!core_pwr_en && !ref_pwr_en));

  // R7
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PS_RELEASE) && !cs_rise && !cfg_wr) |=> !core_pwr_en);

  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_on && conv_done && !cfg_wr) |=> (next_ch != $past(next_ch)));

  // R10
  ref_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (int_ref_in != int_ref_sel)) |=> !result_valid);

endmodule

bind seqpm_ctrl seqpm_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .pm_in        (pm_in),
  .coding_in    (coding_in),
  .int_ref_in   (int_ref_in),
  .conv_done    (conv_done),
  .cs_fall      (cs_fall),
  .cs_rise      (cs_rise),
  .next_ch      (next_ch),
  .coding_sel   (coding_sel),
  .int_ref_sel  (int_ref_sel),
  .core_pwr_en  (core_pwr_en),
  .ref_pwr_en   (ref_pwr_en),
  .result_valid (result_valid),
  .st           (pstate),
  .pm_q         (pm_q),
  .seq_on       (seq_on)
);

// File: tb/sim_seqpm_ctrl.sv
module sim_seqpm_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] pm_in = 2'b00;
  logic [1:0] seq_in = 2'b00;
  logic [0:0] addr_in = 1'b0;
  logic       coding_in = 1'b0;
  logic       int_ref_in = 1'b0;
  logic       conv_done = 1'b0;
  logic       cs_fall = 1'b0;
  logic       cs_rise = 1'b0;
  logic [0:0] next_ch;
  logic       coding_sel, int_ref_sel, core_pwr_en, ref_pwr_en, result_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seqpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .pm_in(pm_in), .seq_in(seq_in),
    .addr_in(addr_in), .coding_in(coding_in), .int_ref_in(int_ref_in),
    .conv_done(conv_done), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .next_ch(next_ch), .coding_sel(coding_sel), .int_ref_sel(int_ref_sel),
    .core_pwr_en(core_pwr_en), .ref_pwr_en(ref_pwr_en), .result_valid(result_valid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] pm, input logic [1:0] sq, input logic ad,
                           input logic cod, input logic rf);
    @(negedge clk);
    pm_in = pm; seq_in = sq; addr_in = ad; coding_in = cod; int_ref_in = rf; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic pulse_fall();
    @(negedge clk); cs_fall = 1'b1;
    @(negedge clk); cs_fall = 1'b0;
  endtask

  task automatic pulse_rise();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "core_pwr_en", core_pwr_en, 1);
    chk("R1", "ref_pwr_en", ref_pwr_en, 0);
    chk("R1", "coding_sel", coding_sel, 0);
    chk("R1", "int_ref_sel", int_ref_sel, 0);
    chk("R1", "next_ch", next_ch, 0);
    chk("R1", "result_valid", result_valid, 1);
  endtask

  task automatic t_normal();
    write_cfg(2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
    chk("R8", "next_ch addressed", next_ch, 1);
    chk("R2", "coding_sel loaded", coding_sel, 1);
    chk("R10", "result_valid after ref change", result_valid, 0);
    chk("R11", "ref_pwr_en internal ref on", ref_pwr_en, 1);
    pulse_done();
    chk("R10", "result_valid after conversion", result_valid, 1);
    pulse_done();
    chk("R3", "core stays on in normal", core_pwr_en, 1);
    // coding_in moved without a write must not reach coding_sel
    @(negedge clk); coding_in = 1'b0; int_ref_in = 1'b0;
    @(negedge clk);
    chk("R2", "coding_sel without write", coding_sel, 1);
    chk("R2", "int_ref_sel without write", int_ref_sel, 1);
  endtask

  task automatic t_standby();
    write_cfg(2'b01, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R10", "same ref keeps valid", result_valid, 1);
    pulse_done();
    chk("R4", "core off after standby conversion", core_pwr_en, 0);
    chk("R11", "ref kept in standby", ref_pwr_en, 1);
    pulse_done();
    chk("R4", "conv_done while asleep ignored", core_pwr_en, 0);
    pulse_fall();
    chk("R5", "core on after cs_fall", core_pwr_en, 1);
    chk("R5", "dummy frame invalid", result_valid, 0);
    pulse_done();
    chk("R5", "core stays on after dummy", core_pwr_en, 1);
    chk("R5", "result valid after dummy", result_valid, 1);
    pulse_done();
    chk("R4", "sleep after valid conversion", core_pwr_en, 0);
  endtask

  task automatic t_shutdown();
    write_cfg(2'b10, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R11", "ref off asleep in auto shutdown", ref_pwr_en, 0);
    chk("R2", "core still asleep after write", core_pwr_en, 0);
    pulse_fall();
    chk("R5", "shutdown wake core", core_pwr_en, 1);
    chk("R5", "shutdown wake invalid", result_valid, 0);
    pulse_done();
    chk("R5", "shutdown dummy done valid", result_valid, 1);
    pulse_done();
    chk("R4", "shutdown sleep core", core_pwr_en, 0);
    chk("R4", "shutdown sleep ref", ref_pwr_en, 0);
  endtask

  task automatic t_full();
    write_cfg(2'b11, 2'b00, 1'b0, 1'b1, 1'b1);
    chk("R6", "full core off", core_pwr_en, 0);
    chk("R6", "full ref off", ref_pwr_en, 0);
    chk("R2", "coding loaded in full", coding_sel, 1);
    pulse_fall();
    pulse_rise();
    chk("R6", "cs edges ignored in full", core_pwr_en, 0);
    write_cfg(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
    chk("R7", "rewrite alone keeps core off", core_pwr_en, 0);
    pulse_fall();
    chk("R7", "cs_fall does not release", core_pwr_en, 0);
    pulse_rise();
    chk("R7", "cs_rise powers core", core_pwr_en, 1);
    chk("R7", "first frame invalid", result_valid, 0);
    pulse_done();
    chk("R7", "valid after frame", result_valid, 1);
    chk("R3", "normal after exit", core_pwr_en, 1);
    // full shutdown straight from the powered state
    write_cfg(2'b11, 2'b00, 1'b0, 1'b1, 1'b1);
    chk("R6", "full from on", core_pwr_en, 0);
    write_cfg(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
    pulse_rise();
    chk("R7", "second exit", core_pwr_en, 1);
    pulse_done();
  endtask

  task automatic t_seq();
    write_cfg(2'b00, 2'b10, 1'b1, 1'b0, 1'b1);
    chk("R9", "entry pointer 0", next_ch, 0);
    pulse_done();
    chk("R9", "step to 1", next_ch, 1);
    pulse_done();
    chk("R9", "wrap to 0", next_ch, 0);
    pulse_done();
    chk("R9", "step to 1 again", next_ch, 1);
    write_cfg(2'b00, 2'b10, 1'b1, 1'b1, 1'b1);
    chk("R9", "rewrite keeps pointer", next_ch, 1);
    chk("R2", "coding updated in sequence", coding_sel, 1);
    write_cfg(2'b00, 2'b11, 1'b1, 1'b0, 1'b1);
    chk("R8", "seq 11 uses address", next_ch, 1);
    pulse_done();
    chk("R8", "seq 11 no rotation", next_ch, 1);
    write_cfg(2'b00, 2'b10, 1'b0, 1'b0, 1'b1);
    chk("R8", "seq 10 addr 0", next_ch, 0);
    pulse_done();
    chk("R8", "addr 0 no rotation", next_ch, 0);
    write_cfg(2'b00, 2'b10, 1'b1, 1'b0, 1'b1);
    chk("R9", "re-entry pointer 0", next_ch, 0);
    pulse_done();
    chk("R9", "re-entry step", next_ch, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_standby();
    t_shutdown();
    t_full();
    t_seq();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule